// File: doc/BRIEF.md
# Asynchronous Character Transmitter

This block is the sending half of an asynchronous serial port. Software or a neighbouring block presents one character at a time on a load handshake. Each accepted character waits in a single-entry holding register until the shifter is free. The shifter then sends it on the serial line as a framed character. A line-control byte sets the frame: it chooses the number of data bits, the stop length, whether a parity bit is inserted and how it is computed, and a break that clamps the line low. The shifter is paced by an external tick that runs at sixteen times the bit rate. Every bit lasts `OVS` ticks, and a half stop bit lasts `OVS/2` ticks.

The frame settings are captured at the moment a character leaves the holding register, so the control byte may be changed for the next character while the current one is still on the wire. Only break acts at once. Two status flags report whether the holding register can take a new character and whether the whole transmit path has gone quiet.

The controller has seven states. `ST_IDLE` is the quiet line. `ST_START` sends the low start bit. `ST_DATA` sends the data bits, least significant first. `ST_PARITY` sends the parity bit. `ST_STOP` sends the high stop time. `ST_BREAK` holds the line while break is requested. `ST_GUARD` is one high bit time that follows a released break.

The transitions are:
- `ST_IDLE` to `ST_BREAK` when break is set. `ST_IDLE` to `ST_START` when a character is held.
- `ST_START` to `ST_DATA` at the end of the bit.
- `ST_DATA` to `ST_PARITY` or to `ST_STOP` after the last data bit, depending on the parity enable.
- `ST_PARITY` to `ST_STOP` at the end of the bit.
- `ST_STOP` to `ST_BREAK`, `ST_START` or `ST_IDLE` at the end of the stop time, checked in that order.
- `ST_BREAK` to `ST_GUARD` when break is cleared.
- `ST_GUARD` to `ST_BREAK` if break comes back. Otherwise, at the end of the bit, to `ST_START` or `ST_IDLE`.

Top module: `serial_char_tx`

## Requirements
- R1: The line idles high. A character is sent as a low start bit, then its data bits least significant first, then parity (if enabled), then the stop time. `line_ctrl[1:0]` = 0, 1, 2, 3 selects 5, 6, 7, 8 data bits. Each bit lasts 16 ticks of `baud_tick`.
- R2: `line_ctrl[2]` = 0 gives a 16-tick stop time. With `line_ctrl[2]` = 1, the stop time is 24 ticks for 5-bit characters and 32 ticks for 6, 7 or 8 bits.
- R3: With `line_ctrl[3]` = 0, no parity bit is sent. This holds whatever the values of `line_ctrl[4]` and `line_ctrl[5]`.
- R4: With `line_ctrl[3]` = 1 and `line_ctrl[5]` = 0, a parity bit follows the data. `line_ctrl[4]` = 1 makes the count of ones in data plus parity even. `line_ctrl[4]` = 0 makes that count odd.
- R5: With `line_ctrl[3]` = 1 and `line_ctrl[5]` = 1, the parity bit is a constant. It is 0 when `line_ctrl[4]` = 1 and 1 when `line_ctrl[4]` = 0.
- R6: While `line_ctrl[6]` is 1, `txd` is 0, including in the middle of a character. `line_ctrl[7]` has no effect on the line.
- R7: No character starts while break is set. After break is released, the line stays high for exactly 16 ticks before a waiting character's start bit.
- R8: `busy` is 1 while the holding register holds a character. A load is taken only when `busy` is 0. A load presented while `busy` is 1 is dropped and never sent.
- R9: A character waiting in the holding register starts in the cycle after the previous character's stop time ends, with no idle gap.
- R10: `hold_empty` is the inverse of `busy`. `tx_empty` is 1 only when the holding register is empty and the controller is in `ST_IDLE`.
- R11: After reset, `txd` is 1, `busy` is 0, and both `hold_empty` and `tx_empty` are 1.
- R12: The frame settings in `line_ctrl[5:0]` are taken when a character starts. Changing them during a character does not alter that character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| line_ctrl | input | 8 | Frame control: length [1:0], long stop [2], parity enable [3], even select [4], stick [5], break [6], bit 7 ignored |
| load | input | 1 | Request to take `load_data` |
| load_data | input | DATA_W | Character to send |
| busy | output | 1 | Holding register occupied; a load is refused |
| txd | output | 1 | Serial line |
| hold_empty | output | 1 | Holding register free |
| tx_empty | output | 1 | Holding register free and shifter idle |

## Verification
Two functions can land on the same clock edge: the end of the stop time and the hand-off of a held character into the shifter. The bench provokes this by loading a second character while the first is still on the wire, then presenting a third load that must be dropped. The captured line must show both frames back to back over exactly their combined tick count, with nothing from the third. A second collision is a break held across a pending character. Judging it requires that the line stays low and that exactly 16 high ticks pass between the release of break and the falling start edge.

// File: rtl/sct_pkg.sv
package sct_pkg;

    // Field positions inside the line-control byte
    localparam int LC_LEN   = 0;
    localparam int LC_STOP  = 2;
    localparam int LC_PEN   = 3;
    localparam int LC_EVEN  = 4;
    localparam int LC_STICK = 5;
    localparam int LC_BRK   = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_BREAK,
        ST_GUARD
    } tx_state_t;

    typedef struct packed {
        logic [1:0] len;
        logic       long_stop;
        logic       par_en;
        logic       par_even;
        logic       par_stick;
    } frame_cfg_t;

    function automatic frame_cfg_t decode_ctrl(input logic [5:0] c);
        frame_cfg_t f;
        f.len       = c[LC_LEN +: 2];
        f.long_stop = c[LC_STOP];
        f.par_en    = c[LC_PEN];
        f.par_even  = c[LC_EVEN];
        f.par_stick = c[LC_STICK];
        return f;
    endfunction

endpackage

// File: rtl/sct_hold.sv
module sct_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] din,
    output logic              full,
    output logic [DATA_W-1:0] dout
);

    logic              full_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (push && !full_q) begin
            full_q <= 1'b1;
            data_q <= din;
        end else if (pop) begin
            full_q <= 1'b0;
        end
    end

    assign full = full_q;
    assign dout = data_q;

endmodule

// File: rtl/sct_parity.sv
module sct_parity #(
    parameter int DATA_W   = 8,
    parameter int MIN_BITS = 5
) (
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        len,
    input  logic              even,
    input  logic              stick,
    output logic              par
);

    logic [DATA_W-1:0] used;

    // Keep only the bits that belong to the selected character length
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign used[i] = data[i] & ((MIN_BITS + int'(len)) > i);
    end

    always_comb begin
        if (stick) par = ~even;
        else if (even) par = ^used;
        else par = ~(^used);
    end

endmodule

// File: rtl/sct_fsm.sv
module sct_fsm
    import sct_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int OVS      = 16,
    parameter int MIN_BITS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              brk,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_long_stop,
    input  logic              cfg_par_en,
    input  logic              par_in,
    output logic              pop,
    output logic              txd,
    output tx_state_t         state_o
);

    localparam int CNT_W = $clog2(2 * OVS);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int HALF  = OVS / 2;
    localparam logic [CNT_W-1:0] LIM_BIT   = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] LIM_ONEHF = CNT_W'(3 * HALF - 1);
    localparam logic [CNT_W-1:0] LIM_TWO   = CNT_W'(2 * OVS - 1);

    tx_state_t         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] shreg_q;
    logic [1:0]        len_q;
    logic              lstop_q;
    logic              pen_q;
    logic              par_q;

    logic [CNT_W-1:0]  lim;
    logic [IDX_W-1:0]  last_idx;
    logic              bit_end;
    logic              timed;
    logic              line;

    // Tick limit for the bit now on the wire
    always_comb begin
        lim = LIM_BIT;
        if (state_q == ST_STOP && lstop_q)
            lim = (len_q == 2'd0) ? LIM_ONEHF : LIM_TWO;
    end

    assign last_idx = IDX_W'(MIN_BITS - 1 + int'(len_q));
    assign bit_end  = tick && (cnt_q == lim);
    assign timed    = (state_q != ST_IDLE) && (state_q != ST_BREAK);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        pop     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (brk) state_d = ST_BREAK;
                else if (hold_full) begin
                    state_d = ST_START;
                    pop     = 1'b1;
                end
            end
            ST_START: begin
                if (bit_end) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (bit_end && idx_q == last_idx)
                    state_d = pen_q ? ST_PARITY : ST_STOP;
            end
            ST_PARITY: begin
                if (bit_end) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (bit_end) begin
                    if (brk) state_d = ST_BREAK;
                    else if (hold_full) begin
                        state_d = ST_START;
                        pop     = 1'b1;
                    end else state_d = ST_IDLE;
                end
            end
            ST_BREAK: begin
                if (!brk) state_d = ST_GUARD;
            end
            ST_GUARD: begin
                if (brk) state_d = ST_BREAK;
                else if (bit_end) begin
                    if (hold_full) begin
                        state_d = ST_START;
                        pop     = 1'b1;
                    end else state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else state_q <= state_d;
    end

    // Tick counter, shifter and frame settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            shreg_q <= '0;
            len_q   <= '0;
            lstop_q <= 1'b0;
            pen_q   <= 1'b0;
            par_q   <= 1'b0;
        end else begin
            if (state_d != state_q || bit_end || !timed) cnt_q <= '0;
            else if (tick) cnt_q <= cnt_q + 1'b1;

            if (pop) begin
                shreg_q <= hold_data;
                idx_q   <= '0;
                len_q   <= cfg_len;
                lstop_q <= cfg_long_stop;
                pen_q   <= cfg_par_en;
                par_q   <= par_in;
            end else if (state_q == ST_DATA && bit_end) begin
                shreg_q <= {1'b0, shreg_q[DATA_W-1:1]};
                idx_q   <= idx_q + 1'b1;
            end
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            ST_START:  line = 1'b0;
            ST_DATA:   line = shreg_q[0];
            ST_PARITY: line = par_q;
            default:   line = 1'b1;
        endcase
        txd = line & ~brk;
    end

    assign state_o = state_q;

endmodule

// File: rtl/serial_char_tx.sv
module serial_char_tx
    import sct_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int OVS      = 16,
    parameter int MIN_BITS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic [7:0]        line_ctrl,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              busy,
    output logic              txd,
    output logic              hold_empty,
    output logic              tx_empty
);

    frame_cfg_t        cfg;
    logic              hold_full;
    logic              pop;
    logic              par_bit;
    logic [DATA_W-1:0] hold_data;
    tx_state_t         fsm_state;
    logic              ctrl_unused;

    assign cfg         = decode_ctrl(line_ctrl[5:0]);
    assign ctrl_unused = line_ctrl[7];

    sct_hold #(.DATA_W(DATA_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (load),
        .pop   (pop),
        .din   (load_data),
        .full  (hold_full),
        .dout  (hold_data)
    );

    sct_parity #(.DATA_W(DATA_W), .MIN_BITS(MIN_BITS)) u_par (
        .data  (hold_data),
        .len   (cfg.len),
        .even  (cfg.par_even),
        .stick (cfg.par_stick),
        .par   (par_bit)
    );

    sct_fsm #(.DATA_W(DATA_W), .OVS(OVS), .MIN_BITS(MIN_BITS)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (baud_tick),
        .brk           (line_ctrl[LC_BRK]),
        .hold_full     (hold_full),
        .hold_data     (hold_data),
        .cfg_len       (cfg.len),
        .cfg_long_stop (cfg.long_stop),
        .cfg_par_en    (cfg.par_en),
        .par_in        (par_bit),
        .pop           (pop),
        .txd           (txd),
        .state_o       (fsm_state)
    );

    assign busy       = hold_full;
    assign hold_empty = ~hold_full;
    assign tx_empty   = ~hold_full && (fsm_state == ST_IDLE);

endmodule

// File: rtl/sct_checker.sv
module sct_checker
    import sct_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      brk,
    input logic      load,
    input logic      busy,
    input logic      txd,
    input logic      hold_empty,
    input logic      tx_empty,
    input tx_state_t state
);

    p_break_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> !txd);

    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && !brk) |-> txd);

    p_empty_chain_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> hold_empty);

    p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !busy) |=> busy);

    p_start_needs_char_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && $past(state) != ST_START) |-> $past(busy));

    p_break_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_BREAK && state != ST_GUARD) |-> ($past(state) != ST_BREAK));

endmodule

bind serial_char_tx sct_checker u_sct_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .brk        (line_ctrl[6]),
    .load       (load),
    .busy       (busy),
    .txd        (txd),
    .hold_empty (hold_empty),
    .tx_empty   (tx_empty),
    .state      (fsm_state)
);

// File: tb/serial_char_tx_bench.sv
module serial_char_tx_bench;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 2;
    localparam int NVEC       = 9;
    // {line_ctrl, data}
    localparam logic [15:0] VEC [NVEC] = '{
        16'h03A5, 16'h0016, 16'h040B, 16'h0D2D, 16'h1A55,
        16'h3BFF, 16'h2B00, 16'h873C, 16'h241F
    };

    logic       clk, rst_n, tick, load, busy, txd, hold_empty, tx_empty;
    logic [7:0] ctrl, ldat;

    int n_tests = 0;
    int n_fail  = 0;
    logic exp_wave [0:1023];
    int exp_len;
    int cap_ticks, cap_bad, cap_at;
    logic busy_seen;

    serial_char_tx u_serial_char_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (tick),
        .line_ctrl  (ctrl),
        .load       (load),
        .load_data  (ldat),
        .busy       (busy),
        .txd        (txd),
        .hold_empty (hold_empty),
        .tx_empty   (tx_empty)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    initial begin
        int ph = 0;
        tick = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            ph   = (ph + 1) % TICK_DIV;
            tick = (ph == 0);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push_bits(input logic v, input int cnt);
        for (int k = 0; k < cnt; k++) begin
            if (exp_len < 1024) exp_wave[exp_len] = v;
            exp_len++;
        end
    endtask

    // Expected line level per tick, built from the requirements
    task automatic add_frame(input logic [7:0] c, input logic [7:0] d);
        int n = 5 + int'(c[1:0]);
        logic [7:0] m = d & (8'hFF >> (8 - n));
        logic p;
        push_bits(1'b0, 16);
        for (int i = 0; i < n; i++) push_bits(d[i], 16);
        if (c[3]) begin
            if (c[5]) p = ~c[4];
            else if (c[4]) p = ^m;
            else p = ~(^m);
            push_bits(p, 16);
        end
        if (!c[2]) push_bits(1'b1, 16);
        else if (n == 5) push_bits(1'b1, 24);
        else push_bits(1'b1, 32);
    endtask

    function automatic string tags_for(input logic [7:0] c);
        string s = "R1";
        if (c[2]) s = {s, " R2"};
        if (!c[3]) s = {s, " R3"};
        else if (c[5]) s = {s, " R5"};
        else s = {s, " R4"};
        if (c[7]) s = {s, " R6"};
        return s;
    endfunction

    // Follows txd from the first low level until tx_empty rises
    task automatic capture();
        int guard = 0;
        cap_ticks = 0;
        cap_bad   = 0;
        cap_at    = -1;
        while (txd !== 1'b0 && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 3000) begin
            cap_bad = 1;
            return;
        end
        guard = 0;
        while (tx_empty !== 1'b1 && guard < 6000) begin
            if (tick) begin
                cap_ticks++;
                if (cap_ticks > exp_len || txd !== exp_wave[cap_ticks-1]) begin
                    cap_bad++;
                    if (cap_at < 0) cap_at = cap_ticks;
                end
            end
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic load_char(input logic [7:0] d);
        int guard = 0;
        @(negedge clk);
        while (busy && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        @(posedge clk);
        #1;
        load = 1'b1;
        ldat = d;
        @(posedge clk);
        #1;
        load = 1'b0;
    endtask

    task automatic set_ctrl(input logic [7:0] c);
        @(posedge clk);
        #1;
        ctrl = c;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog (all R)", 150000, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int bad;
        int g;
        rst_n = 1'b0;
        load  = 1'b0;
        ldat  = 8'h00;
        ctrl  = 8'h03;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(txd == 1'b1, "R11 txd", int'(txd), 1);
        check(busy == 1'b0, "R11 busy", int'(busy), 0);
        check(hold_empty && tx_empty, "R11 empties", int'({hold_empty, tx_empty}), 3);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Table of frames
        for (int v = 0; v < NVEC; v++) begin
            exp_len = 0;
            add_frame(VEC[v][15:8], VEC[v][7:0]);
            set_ctrl(VEC[v][15:8]);
            fork
                capture();
                load_char(VEC[v][7:0]);
            join
            check(cap_bad == 0, tags_for(VEC[v][15:8]), cap_at, -1);
            check(cap_ticks == exp_len, "R2 frame length", cap_ticks, exp_len);
            check(hold_empty && tx_empty, "R10 empty after frame",
                  int'({hold_empty, tx_empty}), 3);
        end

        // R12: settings changed during a character
        set_ctrl(8'h03);
        exp_len = 0;
        add_frame(8'h03, 8'hC3);
        fork
            capture();
            begin
                load_char(8'hC3);
                repeat (40) @(posedge clk);
                #1;
                ctrl = 8'h3C;
            end
        join
        check(cap_bad == 0 && cap_ticks == 160, "R12 latched settings", cap_ticks, 160);

        // R8/R9: back-to-back characters and a refused load
        set_ctrl(8'h03);
        exp_len = 0;
        add_frame(8'h03, 8'h5A);
        add_frame(8'h03, 8'h81);
        fork
            capture();
            begin
                load_char(8'h5A);
                load_char(8'h81);
                @(negedge clk);
                busy_seen = busy;
                @(posedge clk);
                #1;
                load = 1'b1;
                ldat = 8'hE7;
                @(posedge clk);
                #1;
                load = 1'b0;
            end
        join
        check(busy_seen == 1'b1, "R8 busy while held", int'(busy_seen), 1);
        check(cap_bad == 0, "R9 R8 back-to-back waveform", cap_at, -1);
        check(cap_ticks == 320, "R9 no gap between frames", cap_ticks, 320);
        check(tx_empty == 1'b1, "R10 empty after pair", int'(tx_empty), 1);

        // R6/R7: break from idle with a pending character
        set_ctrl(8'h43);
        repeat (4) @(negedge clk);
        check(txd == 1'b0, "R6 break low", int'(txd), 0);
        load_char(8'h96);
        repeat (50) @(negedge clk);
        check(txd == 1'b0 && !hold_empty && !tx_empty, "R7 held during break",
              int'({txd, hold_empty, tx_empty}), 0);
        set_ctrl(8'h03);
        @(negedge clk);
        check(txd == 1'b1, "R7 line high after release", int'(txd), 1);
        g = 0;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (txd == 1'b0) break;
            if (tick) g++;
        end
        check(g == 16, "R7 guard ticks", g, 16);
        exp_len = 0;
        add_frame(8'h03, 8'h96);
        capture();
        check(cap_bad == 0 && cap_ticks == 160, "R7 frame after break", cap_ticks, 160);

        // R6: break in the middle of a character
        load_char(8'h00 ^ 8'hFF);
        repeat (60) @(negedge clk);
        set_ctrl(8'h43);
        bad = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (txd !== 1'b0) bad++;
        end
        check(bad == 0, "R6 break mid-character", bad, 0);
        set_ctrl(8'h03);
        g = 0;
        while (tx_empty !== 1'b1 && g < 3000) begin
            @(negedge clk);
            g++;
        end
        check(tx_empty == 1'b1 && txd == 1'b1, "R10 quiet after break",
              int'({tx_empty, txd}), 3);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule